// File: doc/BRIEF.md
# E1 One-Second Performance Monitor

This block watches the per-frame observations that an E1 framer produces and turns them into per-second performance verdicts. On every frame strobe it samples a set of defect and error indications: frame-alignment-word bit errors, errors in the word between alignment words, CRC-4 block errors, the received E bit, the Sa5 bit and Sa6 nibble, and the loss-of-signal, alarm-indication, loss-of-frame, loss-of-multiframe, remote-alarm and slip indications. A per-event enable mask selects which of these count toward errored seconds. The mask includes several decoded Sa6 patterns, and four of those count only while Sa5 is 1.

A shared one-second tick closes each interval. At that point the block decides whether the second was errored or severely errored and whether the CRC-4 error count was excessive. When the count was excessive it also raises a one-cycle request to force a reframe. A separate window counts received E bits equal to 0 over five consecutive seconds and drives a status level from that count. Each path (for example receive and transmit) has its own thresholds, mask, counters and outputs. Any number of paths can be instantiated.

Top module: `e1_pm_sec`

## Requirements
- R1: While `frame_vld` of a path is 1, each asserted indication whose enable bit is 1 adds one to that second's event count. The enable bit positions in the path's 16-bit mask are: 0 alignment-word error, 1 non-alignment-word error, 2 CRC-4 error, 3 AIS, 4 LOS, 5 slip, 6 remote alarm, 7 loss of frame alignment, 8 loss of multiframe alignment, 9 E bit equal to 0. An indication whose enable bit is 0 has no effect on `es_o` or `ses_o`. Inputs are ignored while `frame_vld` is 0.
- R2: The Sa6 nibble is written b3..b0 with b3 first. Mask bit 10 counts the pattern 001x (b3=0, b2=0, b1=1). Mask bit 11 counts the pattern 00x1 (b3=0, b2=0, b0=1). Both bits count regardless of Sa5.
- R3: Mask bits 12, 13, 14 and 15 count the Sa6 values 0x8, 0xC, 0xE and 0xF respectively, and only while Sa5 is 1.
- R4: `es_o` pulses for exactly one cycle, in the cycle after a `sec_tick` cycle, when the closing second holds at least one enabled event. A frame that arrives in the tick cycle belongs to the closing second.
- R5: `ses_o` pulses together with `es_o` when the closing second's event count is at least the path's SES threshold. A threshold of 0 never asserts it.
- R6: `exc_crc_o` is a level that is updated after every tick. It becomes 1 when the closing second's count of all CRC-4 errors, independent of the mask, is at least the CRC threshold and that threshold is nonzero. Otherwise it becomes 0.
- R7: `reframe_o` pulses for one cycle after each tick at which `exc_crc_o` is set.
- R8: `cre_o` is a level updated after every fifth tick counted from reset. It becomes 1 when the count of E bits equal to 0 over those five seconds is at least the nonzero E-bit threshold, and 0 otherwise.
- R9: All counters saturate at 0xFFFF instead of wrapping.
- R10: Each path's outputs depend only on that path's inputs and configuration.
- R11: While `rst` is 1, and in the first cycle after it, every output is 0 and all counters and the five-second phase restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle strobe closing each second |
| frame_vld | input | NUM_PATHS | Per-path frame strobe qualifying the indications |
| fas_err | input | NUM_PATHS | Alignment-word bit error |
| nfas_err | input | NUM_PATHS | Non-alignment-word bit error |
| crc_err | input | NUM_PATHS | CRC-4 block error |
| ebit | input | NUM_PATHS | Received E bit value (0 is an event) |
| sa5 | input | NUM_PATHS | Received Sa5 bit |
| sa6 | input | 4*NUM_PATHS | Received Sa6 nibble, 4 bits per path |
| los | input | NUM_PATHS | Loss of signal |
| ais | input | NUM_PATHS | Alarm indication signal |
| lfa | input | NUM_PATHS | Loss of frame alignment |
| lmfa | input | NUM_PATHS | Loss of multiframe alignment |
| rfa | input | NUM_PATHS | Remote frame alarm |
| slip | input | NUM_PATHS | Slip |
| ev_en | input | 16*NUM_PATHS | Per-path event enable mask |
| ses_thr | input | CNT_W*NUM_PATHS | Per-path SES threshold |
| crc_thr | input | CNT_W*NUM_PATHS | Per-path excessive CRC threshold |
| cre_thr | input | CNT_W*NUM_PATHS | Per-path five-second E-bit threshold |
| es_o | output | NUM_PATHS | Errored second pulse |
| ses_o | output | NUM_PATHS | Severely errored second pulse |
| exc_crc_o | output | NUM_PATHS | Excessive CRC level |
| reframe_o | output | NUM_PATHS | Forced reframe request pulse |
| cre_o | output | NUM_PATHS | Continuous E-bit status level |

## Verification
The bench tries masked-off indications that a design leaking the mask would count as errored seconds. It tries Sa6 codes with Sa5 low, which a design missing the Sa5 qualification would count. It tries Sa6 patterns that match both the 001x and the 00x1 decode at once. Frames landing in the tick cycle catch a design that drops them or carries them into the next second. A long burst of many events per frame goes past 0xFFFF, and a wrapping counter would then miss an SES against a 0xFFFF threshold. Zero thresholds catch a design that declares on an empty count. Runs of ticks check that the E-bit verdict changes only on every fifth tick. Events on one path alone show whether a design couples the paths.

// File: rtl/e1pm_pkg.sv
package e1pm_pkg;
  localparam int NUM_EV = 16;

  typedef enum logic [3:0] {
    EV_FAS       = 4'd0,
    EV_NFAS      = 4'd1,
    EV_CRC       = 4'd2,
    EV_AIS       = 4'd3,
    EV_LOS       = 4'd4,
    EV_SLIP      = 4'd5,
    EV_RFA       = 4'd6,
    EV_LFA       = 4'd7,
    EV_LMFA      = 4'd8,
    EV_EBIT0     = 4'd9,
    EV_SA6_001X  = 4'd10,
    EV_SA6_00X1  = 4'd11,
    EV_SA6_PWR   = 4'd12,
    EV_SA6_LOSLF = 4'd13,
    EV_SA6_FC    = 4'd14,
    EV_SA6_AIS   = 4'd15
  } ev_idx_e;

  typedef struct packed {
    logic       fas;
    logic       nfas;
    logic       crc;
    logic       ais;
    logic       los;
    logic       slip;
    logic       rfa;
    logic       lfa;
    logic       lmfa;
    logic       ebit;
    logic       sa5;
    logic [3:0] sa6;
  } frm_obs_t;
endpackage

// File: rtl/e1pm_evt_qual.sv
module e1pm_evt_qual
  import e1pm_pkg::*;
#(
  parameter int HW = $clog2(NUM_EV + 1)
) (
  input  logic              vld,
  input  frm_obs_t          obs,
  input  logic [NUM_EV-1:0] en,
  output logic [HW-1:0]     n_hit,
  output logic              crc_hit,
  output logic              ebit0_hit
);
  logic [NUM_EV-1:0] raw;
  logic [NUM_EV-1:0] hit;
  logic              sa6_hi_zero;

  assign sa6_hi_zero = (obs.sa6[3:2] == 2'b00);

  always_comb begin
    raw               = '0;
    raw[EV_FAS]       = obs.fas;
    raw[EV_NFAS]      = obs.nfas;
    raw[EV_CRC]       = obs.crc;
    raw[EV_AIS]       = obs.ais;
    raw[EV_LOS]       = obs.los;
    raw[EV_SLIP]      = obs.slip;
    raw[EV_RFA]       = obs.rfa;
    raw[EV_LFA]       = obs.lfa;
    raw[EV_LMFA]      = obs.lmfa;
    raw[EV_EBIT0]     = ~obs.ebit;
    raw[EV_SA6_001X]  = sa6_hi_zero & obs.sa6[1];
    raw[EV_SA6_00X1]  = sa6_hi_zero & obs.sa6[0];
    raw[EV_SA6_PWR]   = obs.sa5 & (obs.sa6 == 4'h8);
    raw[EV_SA6_LOSLF] = obs.sa5 & (obs.sa6 == 4'hC);
    raw[EV_SA6_FC]    = obs.sa5 & (obs.sa6 == 4'hE);
    raw[EV_SA6_AIS]   = obs.sa5 & (obs.sa6 == 4'hF);
  end

  assign hit = vld ? (raw & en) : '0;

  always_comb begin
    n_hit = '0;
    for (int i = 0; i < NUM_EV; i++) begin
      n_hit = n_hit + HW'(hit[i]);
    end
  end

  assign crc_hit   = vld & obs.crc;
  assign ebit0_hit = vld & ~obs.ebit;
endmodule

// File: rtl/e1pm_sat_acc.sv
module e1pm_sat_acc #(
  parameter int W  = 16,
  parameter int IW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          close,
  input  logic [IW-1:0] inc,
  output logic [W-1:0]  total,
  output logic [W-1:0]  cnt
);
  logic [W:0] sum;

  assign sum   = {1'b0, cnt} + (W+1)'(inc);
  assign total = sum[W] ? {W{1'b1}} : sum[W-1:0];

  always_ff @(posedge clk) begin
    if (rst)        cnt <= '0;
    else if (close) cnt <= '0;
    else            cnt <= total;
  end

  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cnt == {W{1'b1}} && !close) |=> (cnt == {W{1'b1}})); // R9
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    !close |=> (cnt >= $past(cnt))); // R9
endmodule

// File: rtl/e1pm_win.sv
module e1pm_win #(
  parameter int LEN = 5,
  localparam int PW = (LEN > 1) ? $clog2(LEN) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic last
);
  logic [PW-1:0] phase;

  assign last = tick && (phase == PW'(LEN - 1));

  always_ff @(posedge clk) begin
    if (rst)       phase <= '0;
    else if (last) phase <= '0;
    else if (tick) phase <= phase + 1'b1;
  end

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
    phase < PW'(LEN)); // R8
endmodule

// File: rtl/e1pm_path.sv
module e1pm_path
  import e1pm_pkg::*;
#(
  parameter int CW      = 16,
  parameter int WIN_LEN = 5,
  localparam int HW     = $clog2(NUM_EV + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              vld,
  input  frm_obs_t          obs,
  input  logic [NUM_EV-1:0] en,
  input  logic [CW-1:0]     ses_thr,
  input  logic [CW-1:0]     crc_thr,
  input  logic [CW-1:0]     cre_thr,
  output logic              es,
  output logic              ses,
  output logic              exc,
  output logic              refr,
  output logic              cre
);
  logic [HW-1:0] n_hit;
  logic          crc_hit, ebit0_hit, eb_close;
  logic [CW-1:0] ev_tot, ev_cnt, crc_tot, crc_cnt, eb_tot, eb_cnt;
  logic          exc_nxt;

  e1pm_evt_qual #(.HW(HW)) u_qual (
    .vld(vld), .obs(obs), .en(en),
    .n_hit(n_hit), .crc_hit(crc_hit), .ebit0_hit(ebit0_hit)
  );

  e1pm_sat_acc #(.W(CW), .IW(HW)) u_ev_acc (
    .clk(clk), .rst(rst), .close(tick), .inc(n_hit),
    .total(ev_tot), .cnt(ev_cnt)
  );

  e1pm_sat_acc #(.W(CW), .IW(1)) u_crc_acc (
    .clk(clk), .rst(rst), .close(tick), .inc(crc_hit),
    .total(crc_tot), .cnt(crc_cnt)
  );

  e1pm_win #(.LEN(WIN_LEN)) u_win (
    .clk(clk), .rst(rst), .tick(tick), .last(eb_close)
  );

  e1pm_sat_acc #(.W(CW), .IW(1)) u_eb_acc (
    .clk(clk), .rst(rst), .close(eb_close), .inc(ebit0_hit),
    .total(eb_tot), .cnt(eb_cnt)
  );

  assign exc_nxt = (crc_thr != '0) && (crc_tot >= crc_thr);

  always_ff @(posedge clk) begin
    if (rst) begin
      es   <= 1'b0;
      ses  <= 1'b0;
      exc  <= 1'b0;
      refr <= 1'b0;
      cre  <= 1'b0;
    end else begin
      es   <= 1'b0;
      ses  <= 1'b0;
      refr <= 1'b0;
      if (tick) begin
        es   <= (ev_tot != '0);
        ses  <= (ses_thr != '0) && (ev_tot >= ses_thr);
        exc  <= exc_nxt;
        refr <= exc_nxt;
      end
      if (eb_close) begin
        cre <= (cre_thr != '0) && (eb_tot >= cre_thr);
      end
    end
  end

  AST_ES_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
    es |-> $past(tick)); // R4
  AST_SES_WITH_ES: assert property (@(posedge clk) disable iff (rst)
    ses |-> es); // R5
  AST_EXC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(exc)); // R6
  AST_REFR_LEVEL: assert property (@(posedge clk) disable iff (rst)
    refr |-> exc); // R7
  AST_CRE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !eb_close |=> $stable(cre)); // R8
endmodule

// File: rtl/e1_pm_sec.sv
module e1_pm_sec
  import e1pm_pkg::*;
#(
  parameter int NUM_PATHS = 2,
  parameter int CNT_W     = 16,
  parameter int EBIT_SECS = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sec_tick,
  input  logic [NUM_PATHS-1:0]       frame_vld,
  input  logic [NUM_PATHS-1:0]       fas_err,
  input  logic [NUM_PATHS-1:0]       nfas_err,
  input  logic [NUM_PATHS-1:0]       crc_err,
  input  logic [NUM_PATHS-1:0]       ebit,
  input  logic [NUM_PATHS-1:0]       sa5,
  input  logic [4*NUM_PATHS-1:0]     sa6,
  input  logic [NUM_PATHS-1:0]       los,
  input  logic [NUM_PATHS-1:0]       ais,
  input  logic [NUM_PATHS-1:0]       lfa,
  input  logic [NUM_PATHS-1:0]       lmfa,
  input  logic [NUM_PATHS-1:0]       rfa,
  input  logic [NUM_PATHS-1:0]       slip,
  input  logic [NUM_EV*NUM_PATHS-1:0] ev_en,
  input  logic [CNT_W*NUM_PATHS-1:0] ses_thr,
  input  logic [CNT_W*NUM_PATHS-1:0] crc_thr,
  input  logic [CNT_W*NUM_PATHS-1:0] cre_thr,
  output logic [NUM_PATHS-1:0]       es_o,
  output logic [NUM_PATHS-1:0]       ses_o,
  output logic [NUM_PATHS-1:0]       exc_crc_o,
  output logic [NUM_PATHS-1:0]       reframe_o,
  output logic [NUM_PATHS-1:0]       cre_o
);
  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
    frm_obs_t obs;

    always_comb begin
      obs.fas  = fas_err[p];
      obs.nfas = nfas_err[p];
      obs.crc  = crc_err[p];
      obs.ais  = ais[p];
      obs.los  = los[p];
      obs.slip = slip[p];
      obs.rfa  = rfa[p];
      obs.lfa  = lfa[p];
      obs.lmfa = lmfa[p];
      obs.ebit = ebit[p];
      obs.sa5  = sa5[p];
      obs.sa6  = sa6[4*p +: 4];
    end

    e1pm_path #(.CW(CNT_W), .WIN_LEN(EBIT_SECS)) u_path (
      .clk(clk), .rst(rst), .tick(sec_tick), .vld(frame_vld[p]), .obs(obs),
      .en(ev_en[NUM_EV*p +: NUM_EV]),
      .ses_thr(ses_thr[CNT_W*p +: CNT_W]),
      .crc_thr(crc_thr[CNT_W*p +: CNT_W]),
      .cre_thr(cre_thr[CNT_W*p +: CNT_W]),
      .es(es_o[p]), .ses(ses_o[p]), .exc(exc_crc_o[p]),
      .refr(reframe_o[p]), .cre(cre_o[p])
    );
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (es_o == '0 && ses_o == '0 && exc_crc_o == '0 &&
             reframe_o == '0 && cre_o == '0)); // R11
endmodule

// File: tb/tb_e1_pm_sec.sv
`timescale 1ns/1ps
module tb_e1_pm_sec;
  localparam int NP = 2;
  localparam int CW = 16;
  localparam int SMAX = 65535;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sec_tick = 1'b0;
  logic [NP-1:0] frame_vld, fas_err, nfas_err, crc_err, ebit, sa5;
  logic [NP-1:0] los, ais, lfa, lmfa, rfa, slip;
  logic [4*NP-1:0] sa6;
  logic [16*NP-1:0] ev_en;
  logic [CW*NP-1:0] ses_thr, crc_thr, cre_thr;
  logic [NP-1:0] es_o, ses_o, exc_crc_o, reframe_o, cre_o;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  int m_ev[NP], m_crc[NP], m_eb[NP], m_ph[NP];
  bit x_es[NP], x_ses[NP], x_exc[NP], x_refr[NP], x_cre[NP];

  always #4 clk = ~clk;

  e1_pm_sec #(.NUM_PATHS(NP), .CNT_W(CW), .EBIT_SECS(5)) dut (
    .clk(clk), .rst(rst), .sec_tick(sec_tick), .frame_vld(frame_vld),
    .fas_err(fas_err), .nfas_err(nfas_err), .crc_err(crc_err), .ebit(ebit),
    .sa5(sa5), .sa6(sa6), .los(los), .ais(ais), .lfa(lfa), .lmfa(lmfa),
    .rfa(rfa), .slip(slip), .ev_en(ev_en), .ses_thr(ses_thr),
    .crc_thr(crc_thr), .cre_thr(cre_thr), .es_o(es_o), .ses_o(ses_o),
    .exc_crc_o(exc_crc_o), .reframe_o(reframe_o), .cre_o(cre_o)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sat(int v);
    return (v > SMAX) ? SMAX : v;
  endfunction

  // Independent count of enabled events in the current frame of path p.
  function automatic int n_events(int p);
    int n = 0;
    logic [3:0] s = sa6[4*p +: 4];
    logic [15:0] m = ev_en[16*p +: 16];
    if (!frame_vld[p]) return 0;
    if (m[0] && fas_err[p])  n++;
    if (m[1] && nfas_err[p]) n++;
    if (m[2] && crc_err[p])  n++;
    if (m[3] && ais[p])      n++;
    if (m[4] && los[p])      n++;
    if (m[5] && slip[p])     n++;
    if (m[6] && rfa[p])      n++;
    if (m[7] && lfa[p])      n++;
    if (m[8] && lmfa[p])     n++;
    if (m[9] && !ebit[p])    n++;
    if (m[10] && s[3] == 0 && s[2] == 0 && s[1] == 1) n++;
    if (m[11] && s[3] == 0 && s[2] == 0 && s[0] == 1) n++;
    if (sa5[p]) begin
      if (m[12] && s == 4'b1000) n++;
      if (m[13] && s == 4'b1100) n++;
      if (m[14] && s == 4'b1110) n++;
      if (m[15] && s == 4'b1111) n++;
    end
    return n;
  endfunction

  task automatic idle_in();
    frame_vld = '0; fas_err = '0; nfas_err = '0; crc_err = '0; ebit = '1;
    sa5 = '0; sa6 = '0; los = '0; ais = '0; lfa = '0; lmfa = '0;
    rfa = '0; slip = '0; sec_tick = 1'b0;
  endtask

  task automatic model_reset();
    for (int p = 0; p < NP; p++) begin
      m_ev[p] = 0; m_crc[p] = 0; m_eb[p] = 0; m_ph[p] = 0;
      x_es[p] = 0; x_ses[p] = 0; x_exc[p] = 0; x_refr[p] = 0; x_cre[p] = 0;
    end
  endtask

  // One clock: inputs already placed; model the edge, then compare.
  task automatic cyc(bit tk);
    sec_tick = tk;
    for (int p = 0; p < NP; p++) begin
      int sthr = int'(ses_thr[CW*p +: CW]);
      int cthr = int'(crc_thr[CW*p +: CW]);
      int ethr = int'(cre_thr[CW*p +: CW]);
      m_ev[p] = sat(m_ev[p] + n_events(p));
      if (frame_vld[p] && crc_err[p]) m_crc[p] = sat(m_crc[p] + 1);
      if (frame_vld[p] && !ebit[p])   m_eb[p]  = sat(m_eb[p] + 1);
      x_es[p] = 0; x_ses[p] = 0; x_refr[p] = 0;
      if (tk) begin
        x_es[p]   = (m_ev[p] != 0);
        x_ses[p]  = (sthr != 0) && (m_ev[p] >= sthr);
        x_exc[p]  = (cthr != 0) && (m_crc[p] >= cthr);
        x_refr[p] = x_exc[p];
        m_ev[p] = 0; m_crc[p] = 0;
        if (m_ph[p] == 4) begin
          x_cre[p] = (ethr != 0) && (m_eb[p] >= ethr);
          m_eb[p] = 0; m_ph[p] = 0;
        end else m_ph[p]++;
      end
    end
    @(posedge clk);
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      chk(es_o[p] == x_es[p], "R4 es", int'(es_o[p]), int'(x_es[p]));
      chk(ses_o[p] == x_ses[p], "R5 ses", int'(ses_o[p]), int'(x_ses[p]));
      chk(exc_crc_o[p] == x_exc[p], "R6 exc_crc", int'(exc_crc_o[p]), int'(x_exc[p]));
      chk(reframe_o[p] == x_refr[p], "R7 reframe", int'(reframe_o[p]), int'(x_refr[p]));
      chk(cre_o[p] == x_cre[p], "R8 cre", int'(cre_o[p]), int'(x_cre[p]));
    end
    idle_in();
  endtask

  // One frame on path p, then close the second with an empty tick cycle.
  task automatic one_frame_second(int p);
    frame_vld[p] = 1'b1;
    cyc(1'b0);
    cyc(1'b1);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    idle_in();
    ev_en = '1; ses_thr = '0; crc_thr = '0; cre_thr = '0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(es_o == '0 && ses_o == '0 && exc_crc_o == '0 && reframe_o == '0 && cre_o == '0,
        "R11 outputs in reset", int'(es_o), 0);
    rst = 1'b0;
    cyc(1'b0);
    chk(cre_o == '0 && exc_crc_o == '0, "R11 after reset", int'(cre_o), 0);

    // R1: masked-off indication ignored, enabled one counted.
    ev_en = '0; ev_en[2] = 1'b1;
    fas_err[0] = 1'b1; one_frame_second(0);
    chk(es_o[0] == 0, "R1 masked fas", int'(es_o[0]), 0);
    crc_err[0] = 1'b1; fas_err[0] = 1'b0; frame_vld[0] = 1'b1; cyc(1'b1);
    chk(es_o[0] == 1, "R1 crc in tick frame", int'(es_o[0]), 1);
    crc_err[0] = 1'b1; cyc(1'b0);
    cyc(1'b1);
    chk(es_o[0] == 0, "R1 no frame_vld", int'(es_o[0]), 0);

    // R2: Sa6 pattern decodes independent of Sa5.
    ev_en = '0; ev_en[10] = 1'b1;
    sa6[3:0] = 4'b0010; one_frame_second(0);
    chk(es_o[0] == 1, "R2 001x", int'(es_o[0]), 1);
    sa6[3:0] = 4'b0001; one_frame_second(0);
    chk(es_o[0] == 0, "R2 00x1 masked", int'(es_o[0]), 0);
    ev_en[11] = 1'b1; ses_thr[15:0] = 16'd2;
    sa6[3:0] = 4'b0011; one_frame_second(0);
    chk(ses_o[0] == 1, "R2 both patterns", int'(ses_o[0]), 1);

    // R3: codes 8/C/E/F need Sa5.
    ev_en = '0; ev_en[12] = 1'b1; ev_en[15] = 1'b1; ses_thr = '0;
    sa6[3:0] = 4'h8; sa5[0] = 1'b0; one_frame_second(0);
    chk(es_o[0] == 0, "R3 sa5 low", int'(es_o[0]), 0);
    sa6[3:0] = 4'h8; sa5[0] = 1'b1; one_frame_second(0);
    chk(es_o[0] == 1, "R3 sa5 high", int'(es_o[0]), 1);
    sa6[3:0] = 4'hF; sa5[0] = 1'b1; one_frame_second(0);
    chk(es_o[0] == 1, "R3 code F", int'(es_o[0]), 1);

    // R10: path 1 events leave path 0 quiet.
    ev_en = '1; fas_err[1] = 1'b1; one_frame_second(1);
    chk(es_o[1] == 1 && es_o[0] == 0, "R10 isolation", int'(es_o), 2);

    // R6/R7: CRC counting ignores the mask; zero threshold disables.
    ev_en = '0; crc_thr[15:0] = 16'd3;
    for (int i = 0; i < 3; i++) begin frame_vld[0] = 1'b1; crc_err[0] = 1'b1; cyc(1'b0); end
    cyc(1'b1);
    chk(exc_crc_o[0] == 1 && reframe_o[0] == 1 && es_o[0] == 0, "R6 exc at threshold",
        int'(exc_crc_o[0]), 1);
    cyc(1'b0);
    chk(reframe_o[0] == 0 && exc_crc_o[0] == 1, "R7 one-cycle pulse", int'(reframe_o[0]), 0);
    crc_thr = '0; frame_vld[0] = 1'b1; crc_err[0] = 1'b1; cyc(1'b1);
    chk(exc_crc_o[0] == 0, "R6 zero threshold", int'(exc_crc_o[0]), 0);

    // R9: saturation of the event counter against a 0xFFFF threshold.
    ev_en = '1; ses_thr[15:0] = 16'hFFFF;
    for (int i = 0; i < 6000; i++) begin
      frame_vld[0] = 1'b1; fas_err[0] = 1'b1; nfas_err[0] = 1'b1; crc_err[0] = 1'b1;
      ais[0] = 1'b1; los[0] = 1'b1; slip[0] = 1'b1; rfa[0] = 1'b1; lfa[0] = 1'b1;
      lmfa[0] = 1'b1; ebit[0] = 1'b0; sa6[3:0] = 4'b0011;
      cyc(1'b0);
    end
    cyc(1'b1);
    chk(ses_o[0] == 1, "R9 saturated SES", int'(ses_o[0]), 1);

    // R8: five-second E-bit window, then random mix.
    ses_thr = '0; cre_thr[15:0] = 16'd4; cre_thr[31:16] = 16'd2;
    for (int s = 0; s < 10; s++) begin
      frame_vld[0] = 1'b1; ebit[0] = 1'b0; cyc(1'b0);
      cyc(1'b1);
    end
    chk(cre_o[0] == 1 && cre_o[1] == 0, "R8 window", int'(cre_o), 1);

    for (int s = 0; s < 80; s++) begin
      ev_en   = {$urandom, $urandom};
      ses_thr = {16'($urandom_range(0, 6)), 16'($urandom_range(0, 6))};
      crc_thr = {16'($urandom_range(0, 4)), 16'($urandom_range(0, 4))};
      cre_thr = {16'($urandom_range(0, 8)), 16'($urandom_range(0, 8))};
      for (int c = 0; c < 20; c++) begin
        for (int p = 0; p < NP; p++) begin
          frame_vld[p] = ($urandom_range(0, 2) != 0);
          fas_err[p]  = ($urandom_range(0, 9) == 0);
          nfas_err[p] = ($urandom_range(0, 9) == 0);
          crc_err[p]  = ($urandom_range(0, 6) == 0);
          ebit[p]     = ($urandom_range(0, 5) != 0);
          ais[p]      = ($urandom_range(0, 15) == 0);
          los[p]      = ($urandom_range(0, 15) == 0);
          slip[p]     = ($urandom_range(0, 15) == 0);
          rfa[p]      = ($urandom_range(0, 15) == 0);
          lfa[p]      = ($urandom_range(0, 15) == 0);
          lmfa[p]     = ($urandom_range(0, 15) == 0);
          sa5[p]      = $urandom_range(0, 1);
          sa6[4*p +: 4] = 4'($urandom);
        end
        cyc(c == 19);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule